// File: doc/BRIEF.md
# Banked CPU Register File with Control Registers

This block holds the architectural registers of a 32-bit processor core. It has sixteen general-purpose registers with two combinational read ports and one write port that updates on the clock edge. It also has a small bank of numbered control registers, reached only through a separate control read/write port. That port is used by the move-to-control and move-from-control instructions.

General-purpose slot 15 is the stack pointer, but it has no storage of its own. On every access it maps onto one of two control registers: the interrupt-mode stack pointer or the user-mode stack pointer. The stack-mode bit of the status word picks which one, as that bit stands at the time of the access.

A narrow bit-operation port can set or clear three status flags (stack mode, interrupt enable, carry) without a full control write. A backup-PC strobe captures a program counter value into the backup-PC control register, for use by the exception logic that sits outside this block.

Top module: `cpu_regbank`

## Requirements
- R1: Slots 0 to 14 are 32-bit registers. A slot is written on the rising clock edge when gpWrEn is high and gpWrAddr selects it. Both read ports return the addressed slot combinationally. Slot 14, the link register, is ordinary storage.
- R2: A read or write of slot 15 goes to control register 2 when status bit 7 (stack mode) is 0, and to control register 3 when it is 1. For a write, the bit used is the value held before the clock edge.
- R3: Control numbers 0 (status word), 2 (interrupt stack pointer), 3 (user stack pointer), 6 (backup PC) and 7 (floating-point status) are 32-bit registers. They are written on the clock edge through crWrEn/crWrAddr/crWrData and read combinationally on crRdData.
- R4: Control number 1 reads as status bit 0 (carry), zero-extended to 32 bits. Writes to number 1 change nothing.
- R5: Control numbers 4, 5 and 8 to 15 read as zero. Writes to them change nothing.
- R6: When flagEn is high, the status bits at positions 7, 6 and 0 whose flagBits bit is 1 become flagSet (1 = set, 0 = clear). Every other status bit, and every flagBits position other than 7, 6 and 0, has no effect.
- R7: A control write to number 0 in the same cycle as a flag operation wins, and the flag operation is dropped.
- R8: When a slot-15 write and a control write reach the same stack pointer in one cycle, the control write's data is stored.
- R9: When bpcLoad is high, bpcValue is stored into control number 6, taking priority over a control write to number 6 in the same cycle.
- R10: Reads never forward same-cycle write data. A read of a register being written returns the old value until the clock edge.
- R11: After reset the status word, both stack pointers, the backup PC and the floating-point status read as zero. Slots 0 to 14 are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data |
| gpWrEn | input | 1 | General-purpose write enable |
| gpWrAddr | input | 4 | General-purpose write register number |
| gpWrData | input | 32 | General-purpose write data |
| crRdAddr | input | 4 | Control register read number |
| crRdData | output | 32 | Control register read data |
| crWrEn | input | 1 | Control register write enable |
| crWrAddr | input | 4 | Control register write number |
| crWrData | input | 32 | Control register write data |
| flagEn | input | 1 | Status flag operation enable |
| flagSet | input | 1 | 1 sets the selected flags, 0 clears them |
| flagBits | input | 32 | Flag select, only positions 7, 6, 0 count |
| bpcLoad | input | 1 | Backup PC capture strobe |
| bpcValue | input | 32 | PC value to capture |

## Verification
The assertions assume that every input is a known value whenever reset is released. They also assume the caller may place all three write sources (general-purpose, control, flag) and the backup-PC strobe in one cycle, with no ordering between them. The stack-pointer alias checks compare the two read paths only in cycles where the control read number matches the live stack-mode selection. The stimulus never depends on that match happening, but the random phase draws the control read number from a small range so that the match occurs often. Directed cycles put every same-cycle collision named in the requirements on the inputs at once.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int CR_AW = 4;

  localparam logic [CR_AW-1:0] CR_PSW  = 4'd0;
  localparam logic [CR_AW-1:0] CR_COND = 4'd1;
  localparam logic [CR_AW-1:0] CR_SPI  = 4'd2;
  localparam logic [CR_AW-1:0] CR_SPU  = 4'd3;
  localparam logic [CR_AW-1:0] CR_BPC  = 4'd6;
  localparam logic [CR_AW-1:0] CR_FPSR = 4'd7;

  // Write strobes from the control module; each storage element has at
  // most one source strobe active in a cycle after priority resolution.
  typedef struct packed {
    logic gpCellEn;
    logic spiGp;
    logic spuGp;
    logic spiCr;
    logic spuCr;
    logic pswCr;
    logic pswFlag;
    logic bpcCr;
    logic bpcPc;
    logic fpsrCr;
  } wrStrobe_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              gpWrEn,
  input  logic [ADDR_W-1:0] gpWrAddr,
  input  logic              crWrEn,
  input  logic [CR_AW-1:0]  crWrAddr,
  input  logic              flagEn,
  input  logic              bpcLoad,
  input  logic              stackMode,
  output wrStrobe_t         stb
);

  localparam int GP_NUM = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] SP_IDX = ADDR_W'(GP_NUM - 1);

  logic gpToSp;
  logic crPsw, crSpi, crSpu, crBpc, crFpsr;

  always_comb begin
    gpToSp = gpWrEn && (gpWrAddr == SP_IDX);
    crPsw  = crWrEn && (crWrAddr == CR_PSW);
    crSpi  = crWrEn && (crWrAddr == CR_SPI);
    crSpu  = crWrEn && (crWrAddr == CR_SPU);
    crBpc  = crWrEn && (crWrAddr == CR_BPC);
    crFpsr = crWrEn && (crWrAddr == CR_FPSR);

    stb          = '0;
    stb.gpCellEn = gpWrEn && (gpWrAddr != SP_IDX);
    // control write beats a slot-15 write to the same stack pointer
    stb.spiCr    = crSpi;
    stb.spuCr    = crSpu;
    stb.spiGp    = gpToSp && !stackMode && !crSpi;
    stb.spuGp    = gpToSp &&  stackMode && !crSpu;
    // full status write beats a flag operation
    stb.pswCr    = crPsw;
    stb.pswFlag  = flagEn && !crPsw;
    // captured PC beats a control write to the backup PC
    stb.bpcPc    = bpcLoad;
    stb.bpcCr    = crBpc && !bpcLoad;
    stb.fpsrCr   = crFpsr;
  end

endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SM_POS = 7,
  parameter int IE_POS = 6,
  parameter int C_POS  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] gpWrAddr,
  input  logic [DATA_W-1:0] gpWrData,
  input  logic [CR_AW-1:0]  crRdAddr,
  input  logic [DATA_W-1:0] crWrData,
  input  logic              flagSet,
  input  logic [DATA_W-1:0] flagBits,
  input  logic [DATA_W-1:0] bpcValue,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] crRdData,
  output logic [DATA_W-1:0] pswQ
);

  localparam int GP_NUM = 2 ** ADDR_W;
  localparam int CELL_NUM = GP_NUM - 1;
  localparam logic [ADDR_W-1:0] SP_IDX = ADDR_W'(CELL_NUM);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << SM_POS) | (DATA_W'(1) << IE_POS) | (DATA_W'(1) << C_POS);

  logic [DATA_W-1:0] cells [CELL_NUM];
  logic [DATA_W-1:0] spiQ, spuQ, bpcQ, fpsrQ;
  logic [DATA_W-1:0] spLive, flagSel, pswFlagged;

  // plain storage slots, no reset
  for (genvar i = 0; i < CELL_NUM; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (stb.gpCellEn && (gpWrAddr == ADDR_W'(i))) cells[i] <= gpWrData;
    end
  end

  assign flagSel    = flagBits & FLAG_MASK;
  assign pswFlagged = flagSet ? (pswQ | flagSel) : (pswQ & ~flagSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pswQ  <= '0;
      spiQ  <= '0;
      spuQ  <= '0;
      bpcQ  <= '0;
      fpsrQ <= '0;
    end else begin
      if (stb.pswCr)        pswQ  <= crWrData;
      else if (stb.pswFlag) pswQ  <= pswFlagged;
      if (stb.spiCr)        spiQ  <= crWrData;
      else if (stb.spiGp)   spiQ  <= gpWrData;
      if (stb.spuCr)        spuQ  <= crWrData;
      else if (stb.spuGp)   spuQ  <= gpWrData;
      if (stb.bpcPc)        bpcQ  <= bpcValue;
      else if (stb.bpcCr)   bpcQ  <= crWrData;
      if (stb.fpsrCr)       fpsrQ <= crWrData;
    end
  end

  assign spLive = pswQ[SM_POS] ? spuQ : spiQ;

  function automatic logic [DATA_W-1:0] gpRead(input logic [ADDR_W-1:0] a);
    if (a == SP_IDX) return spLive;
    return cells[a];
  endfunction

  assign rdDataA = gpRead(rdAddrA);
  assign rdDataB = gpRead(rdAddrB);

  always_comb begin
    unique case (crRdAddr)
      CR_PSW:  crRdData = pswQ;
      CR_COND: crRdData = {{(DATA_W-1){1'b0}}, pswQ[C_POS]};
      CR_SPI:  crRdData = spiQ;
      CR_SPU:  crRdData = spuQ;
      CR_BPC:  crRdData = bpcQ;
      CR_FPSR: crRdData = fpsrQ;
      default: crRdData = '0;
    endcase
  end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SM_POS = 7,
  parameter int IE_POS = 6,
  parameter int C_POS  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              gpWrEn,
  input  logic [ADDR_W-1:0] gpWrAddr,
  input  logic [DATA_W-1:0] gpWrData,
  input  logic [CR_AW-1:0]  crRdAddr,
  output logic [DATA_W-1:0] crRdData,
  input  logic              crWrEn,
  input  logic [CR_AW-1:0]  crWrAddr,
  input  logic [DATA_W-1:0] crWrData,
  input  logic              flagEn,
  input  logic              flagSet,
  input  logic [DATA_W-1:0] flagBits,
  input  logic              bpcLoad,
  input  logic [DATA_W-1:0] bpcValue
);

  wrStrobe_t         stb;
  logic [DATA_W-1:0] pswQ;

  regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .gpWrEn    (gpWrEn),
    .gpWrAddr  (gpWrAddr),
    .crWrEn    (crWrEn),
    .crWrAddr  (crWrAddr),
    .flagEn    (flagEn),
    .bpcLoad   (bpcLoad),
    .stackMode (pswQ[SM_POS]),
    .stb       (stb)
  );

  regbank_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SM_POS(SM_POS), .IE_POS(IE_POS), .C_POS(C_POS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .gpWrAddr (gpWrAddr),
    .gpWrData (gpWrData),
    .crRdAddr (crRdAddr),
    .crWrData (crWrData),
    .flagSet  (flagSet),
    .flagBits (flagBits),
    .bpcValue (bpcValue),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .crRdData (crRdData),
    .pswQ     (pswQ)
  );

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SM_POS = 7,
  parameter int IE_POS = 6,
  parameter int C_POS  = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              gpWrEn,
  input logic [ADDR_W-1:0] gpWrAddr,
  input logic [CR_AW-1:0]  crRdAddr,
  input logic [DATA_W-1:0] crRdData,
  input logic              crWrEn,
  input logic [CR_AW-1:0]  crWrAddr,
  input logic [DATA_W-1:0] crWrData,
  input logic              flagEn,
  input logic              bpcLoad,
  input logic [DATA_W-1:0] bpcValue,
  input logic [DATA_W-1:0] pswQ
);

  localparam logic [ADDR_W-1:0] SP_IDX = ADDR_W'(2 ** ADDR_W - 1);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << SM_POS) | (DATA_W'(1) << IE_POS) | (DATA_W'(1) << C_POS);

  logic [CR_AW-1:0] liveSpNum;
  logic             crReserved;
  assign liveSpNum  = pswQ[SM_POS] ? CR_SPU : CR_SPI;
  assign crReserved = (crRdAddr == 4'd4) || (crRdAddr == 4'd5) || (crRdAddr > CR_FPSR);

  // R2: slot 15 and the selected stack pointer are the same storage
  assert_sp_alias_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == SP_IDX && crRdAddr == liveSpNum) |-> rdDataA == crRdData);

  // R4: condition register is the carry bit zero-extended
  assert_cond_view_R4: assert property (@(posedge clk) disable iff (!rstN)
    (crRdAddr == CR_COND) |-> crRdData == {{(DATA_W-1){1'b0}}, pswQ[C_POS]});

  // R5: unused control numbers read as zero
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    crReserved |-> crRdData == '0);

  // R6: a flag operation leaves every non-flag status bit alone
  assert_flag_scope_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && !(crWrEn && crWrAddr == CR_PSW))
      |=> (pswQ & ~FLAG_MASK) == ($past(pswQ) & ~FLAG_MASK));

  // R7: a full status write beats a flag operation
  assert_psw_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && crWrAddr == CR_PSW) |=> pswQ == $past(crWrData));

  // R8: control write wins over a slot-15 write to the same pointer
  assert_sp_collision_R8: assert property (@(posedge clk) disable iff (!rstN)
    (gpWrEn && gpWrAddr == SP_IDX && crWrEn && crWrAddr == liveSpNum)
      |=> (crRdAddr != $past(crWrAddr) || crRdData == $past(crWrData)));

  // R9: captured PC lands in the backup PC
  assert_bpc_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    bpcLoad |=> (crRdAddr != CR_BPC || crRdData == $past(bpcValue)));

endmodule

bind cpu_regbank regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SM_POS(SM_POS), .IE_POS(IE_POS), .C_POS(C_POS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdAddrA  (rdAddrA),
  .rdDataA  (rdDataA),
  .gpWrEn   (gpWrEn),
  .gpWrAddr (gpWrAddr),
  .crRdAddr (crRdAddr),
  .crRdData (crRdData),
  .crWrEn   (crWrEn),
  .crWrAddr (crWrAddr),
  .crWrData (crWrData),
  .flagEn   (flagEn),
  .bpcLoad  (bpcLoad),
  .bpcValue (bpcValue),
  .pswQ     (pswQ)
);

// File: tb/sim_cpu_regbank.sv
module sim_cpu_regbank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  rdAddrA, rdAddrB, gpWrAddr, crRdAddr, crWrAddr;
  logic [31:0] rdDataA, rdDataB, crRdData;
  logic        gpWrEn, crWrEn, flagEn, flagSet, bpcLoad;
  logic [31:0] gpWrData, crWrData, flagBits, bpcValue;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cpu_regbank u0 (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .gpWrEn(gpWrEn), .gpWrAddr(gpWrAddr), .gpWrData(gpWrData),
    .crRdAddr(crRdAddr), .crRdData(crRdData),
    .crWrEn(crWrEn), .crWrAddr(crWrAddr), .crWrData(crWrData),
    .flagEn(flagEn), .flagSet(flagSet), .flagBits(flagBits),
    .bpcLoad(bpcLoad), .bpcValue(bpcValue)
  );

  int nChecks = 0;
  int nFails  = 0;

  // behavioural reference state
  logic [31:0] mGp [15];
  bit          mValid [15];
  logic [31:0] mPsw, mSpi, mSpu, mBpc, mFpsr;

  function automatic logic [31:0] refGp(input logic [3:0] a);
    if (a == 4'd15) return mPsw[7] ? mSpu : mSpi;
    return mGp[a];
  endfunction

  function automatic logic [31:0] refCr(input logic [3:0] a);
    case (a)
      4'd0: return mPsw;
      4'd1: return {31'b0, mPsw[0]};
      4'd2: return mSpi;
      4'd3: return mSpu;
      4'd6: return mBpc;
      4'd7: return mFpsr;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string crTag(input logic [3:0] a);
    if (a == 4'd1) return "R4";
    if (a == 4'd0 || a == 4'd2 || a == 4'd3 || a == 4'd6 || a == 4'd7) return "R3";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareNow(input string tag);
    if (rdAddrA == 4'd15 || mValid[rdAddrA])
      check(tag != "" ? tag : (rdAddrA == 4'd15 ? "R2" : "R1"), rdDataA, refGp(rdAddrA));
    if (rdAddrB == 4'd15 || mValid[rdAddrB])
      check(tag != "" ? tag : (rdAddrB == 4'd15 ? "R2" : "R1"), rdDataB, refGp(rdAddrB));
    check(tag != "" ? tag : crTag(crRdAddr), crRdData, refCr(crRdAddr));
  endtask

  task automatic modelClock();
    logic [31:0] nPsw, nSpi, nSpu, nBpc, nFpsr, sel;
    nPsw = mPsw; nSpi = mSpi; nSpu = mSpu; nBpc = mBpc; nFpsr = mFpsr;
    if (gpWrEn) begin
      if (gpWrAddr != 4'd15) begin
        mGp[gpWrAddr] = gpWrData;
        mValid[gpWrAddr] = 1'b1;
      end else if (mPsw[7]) nSpu = gpWrData;
      else nSpi = gpWrData;
    end
    if (flagEn && !(crWrEn && crWrAddr == 4'd0)) begin
      sel = flagBits & 32'h0000_00C1;
      nPsw = flagSet ? (mPsw | sel) : (mPsw & ~sel);
    end
    if (crWrEn) begin
      case (crWrAddr)
        4'd0: nPsw  = crWrData;
        4'd2: nSpi  = crWrData;
        4'd3: nSpu  = crWrData;
        4'd6: nBpc  = crWrData;
        4'd7: nFpsr = crWrData;
        default: ;
      endcase
    end
    if (bpcLoad) nBpc = bpcValue;
    mPsw = nPsw; mSpi = nSpi; mSpu = nSpu; mBpc = nBpc; mFpsr = nFpsr;
  endtask

  task automatic idle();
    rdAddrA = 4'd0; rdAddrB = 4'd0; crRdAddr = 4'd0;
    gpWrEn = 1'b0; gpWrAddr = 4'd0; gpWrData = 32'h0;
    crWrEn = 1'b0; crWrAddr = 4'd0; crWrData = 32'h0;
    flagEn = 1'b0; flagSet = 1'b0; flagBits = 32'h0;
    bpcLoad = 1'b0; bpcValue = 32'h0;
  endtask

  // inputs are already set at the falling edge; compare, clock, advance
  task automatic step(input string tag);
    #1 compareNow(tag);
    @(posedge clk);
    modelClock();
    @(negedge clk);
    idle();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    idle();
    rstN = 1'b0;
    for (int i = 0; i < 15; i++) mValid[i] = 1'b0;
    mPsw = '0; mSpi = '0; mSpu = '0; mBpc = '0; mFpsr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset values of every control number
    for (int a = 0; a < 16; a++) begin
      crRdAddr = 4'(a);
      rdAddrA = 4'd15;
      step("R11");
    end

    // R1: fill slots 0..14, then read back pairwise
    for (int i = 0; i < 15; i++) begin
      gpWrEn = 1'b1; gpWrAddr = 4'(i); gpWrData = 32'h1111_0101 * (i + 3);
      step("R1");
    end
    for (int i = 0; i < 15; i++) begin
      rdAddrA = 4'(i); rdAddrB = 4'(14 - i);
      step("R1");
    end

    // R2: stack mode 0 -> slot 15 is control 2
    gpWrEn = 1'b1; gpWrAddr = 4'd15; gpWrData = 32'hA0A0_1000;
    step("R2");
    rdAddrA = 4'd15; crRdAddr = 4'd2;
    step("R2");
    flagEn = 1'b1; flagSet = 1'b1; flagBits = 32'h0000_0080;
    step("R2");
    gpWrEn = 1'b1; gpWrAddr = 4'd15; gpWrData = 32'hB0B0_2000;
    step("R2");
    rdAddrA = 4'd15; crRdAddr = 4'd3;
    step("R2");
    rdAddrB = 4'd15; crRdAddr = 4'd2;
    step("R2");

    // R10: same-cycle read of a register being written returns the old value
    gpWrEn = 1'b1; gpWrAddr = 4'd5; gpWrData = 32'hDEAD_0005;
    rdAddrA = 4'd5; rdAddrB = 4'd5;
    step("R10");
    crWrEn = 1'b1; crWrAddr = 4'd7; crWrData = 32'h0F0F_7777; crRdAddr = 4'd7;
    step("R10");
    rdAddrA = 4'd5; crRdAddr = 4'd7;
    step("R10");

    // R8: stack mode 1, slot-15 write and control-3 write collide
    gpWrEn = 1'b1; gpWrAddr = 4'd15; gpWrData = 32'h1111_1111;
    crWrEn = 1'b1; crWrAddr = 4'd3; crWrData = 32'h2222_2222;
    step("R8");
    crRdAddr = 4'd3; rdAddrA = 4'd15;
    step("R8");

    // R9: PC capture beats control write to 6
    bpcLoad = 1'b1; bpcValue = 32'h0000_4A20;
    crWrEn = 1'b1; crWrAddr = 4'd6; crWrData = 32'h7777_0000;
    step("R9");
    crRdAddr = 4'd6;
    step("R9");
    crWrEn = 1'b1; crWrAddr = 4'd6; crWrData = 32'h7777_0004;
    step("R3");
    crRdAddr = 4'd6;
    step("R3");

    // R7: full status write beats a flag set of everything
    crWrEn = 1'b1; crWrAddr = 4'd0; crWrData = 32'h1234_5600;
    flagEn = 1'b1; flagSet = 1'b1; flagBits = 32'hFFFF_FFFF;
    step("R7");
    crRdAddr = 4'd0;
    step("R7");

    // R6: flags touch only bits 7, 6, 0
    crWrEn = 1'b1; crWrAddr = 4'd0; crWrData = 32'h5A5A_5A3C;
    step("R6");
    flagEn = 1'b1; flagSet = 1'b1; flagBits = 32'hFFFF_FFFF;
    step("R6");
    crRdAddr = 4'd0;
    step("R6");
    crRdAddr = 4'd1;
    step("R6");
    flagEn = 1'b1; flagSet = 1'b0; flagBits = 32'hFFFF_FF3E;
    step("R6");
    crRdAddr = 4'd0;
    step("R6");
    flagEn = 1'b1; flagSet = 1'b0; flagBits = 32'h0000_00C1;
    step("R6");
    crRdAddr = 4'd0;
    step("R6");

    // R4: writes to control 1 are ignored
    crWrEn = 1'b1; crWrAddr = 4'd1; crWrData = 32'hFFFF_FFFF;
    step("R4");
    crRdAddr = 4'd1;
    step("R4");
    crRdAddr = 4'd0;
    step("R4");

    // R5: unused numbers ignore writes and read zero
    for (int a = 4; a < 16; a++) begin
      if (a == 6 || a == 7) continue;
      crWrEn = 1'b1; crWrAddr = 4'(a); crWrData = 32'hCAFE_0000 | 32'(a);
      step("R5");
      crRdAddr = 4'(a);
      step("R5");
    end
    for (int a = 0; a < 8; a++) begin
      crRdAddr = 4'(a);
      step("R5");
    end

    // random traffic, all sources at once, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      rdAddrA  = 4'($urandom_range(0, 15));
      rdAddrB  = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
      crRdAddr = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                             : 4'($urandom_range(0, 3));
      gpWrEn   = 1'($urandom_range(0, 1));
      gpWrAddr = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
      gpWrData = $urandom();
      crWrEn   = ($urandom_range(0, 2) == 0);
      crWrAddr = 4'($urandom_range(0, 15));
      crWrData = $urandom();
      flagEn   = ($urandom_range(0, 3) == 0);
      flagSet  = 1'($urandom_range(0, 1));
      flagBits = $urandom();
      bpcLoad  = ($urandom_range(0, 7) == 0);
      bpcValue = $urandom();
      step("");
    end

    finishRun();
  end

endmodule